// File: doc/BRIEF.md
# Supply-Loss Access Guard for a Byte-Wide RAM

This block stands between a host's active-low strobe lines (chip enable, output enable, write enable) and an on-chip byte-wide RAM. It watches two digital supply flags from analog comparators. `sup_hi` means the supply is above the deselect threshold. `sup_sw` means the supply is above the battery switchover threshold. From these flags it decides when the host may reach the array. While the supply is out of tolerance, the RAM strobes are held inactive and the data bus driver is turned off. After the supply returns, access stays closed for a recovery interval. A fast collapse straight through the deselect window is modelled as protection that arrives a bounded number of cycles late.

On every power-up the block samples a battery-good input exactly once. If the battery was low, it raises a battery-low flag. That flag silently swallows the next host write and then clears itself. Software can detect the swallowed write by writing a location, reading it back and finding it unchanged. The flag is also visible on a status output.

The supply state machine has five states:
- `PS_BATT`: supply below switchover, running on the battery.
- `PS_WINDOW`: supply above switchover but below the deselect threshold.
- `PS_RECOVER`: the recovery count is running.
- `PS_RUN`: access is open.
- `PS_LAG`: the late-protection interval after a fast fall.

Its transitions are:
- power-up sample: `PS_BATT`→`PS_WINDOW` when `sup_sw` is seen high.
- battery drop: `PS_WINDOW`/`PS_RECOVER`→`PS_BATT` when `sup_sw` is low.
- recovery start: `PS_WINDOW`→`PS_RECOVER` when `sup_hi` is high.
- recovery abort: `PS_RECOVER`→`PS_WINDOW` when `sup_hi` drops.
- recovery done: `PS_RECOVER`→`PS_RUN` after the last recovery cycle.
- slow fall: `PS_RUN`→`PS_WINDOW` when `sup_hi` is low and `sup_sw` is high.
- fast fall: `PS_RUN`→`PS_LAG` when both flags are seen low in the same cycle.
- lag expiry: `PS_LAG`→`PS_BATT` after the last lag cycle.
- lag cut: `PS_LAG`→`PS_WINDOW` when `sup_sw` returns.

Top module: `pfg_gate`

## Requirements
- R1: Whenever `sup_hi` is 0 and `sup_sw` is 1, `ram_ce_n` and `ram_oe_n` are 1 and `dq_drive` is 0, whatever the host lines do.
- R2: `ram_we_n` is 0 only while access is open and both `host_ce_n` and `host_we_n` are 0; in any deselected state it stays 1.
- R3: On the first clock edge with `sup_sw` seen high from `PS_BATT`, `batt_low` takes the inverse of `batt_good`. Later changes of `batt_good` have no effect until the next power-up.
- R4: While `batt_low` is 1, `ram_we_n` stays 1 for a host write, while `ram_ce_n` still follows `host_ce_n`.
- R5: After a swallowed write, `batt_low` clears on the first clock edge at which no write is presented. The next write then reaches the RAM.
- R6: After `sup_hi` is seen high, access stays closed for REC_CYC = CLK_KHZ·REC_US/1000 cycles and opens in the following cycle. If `sup_hi` drops during recovery, the count restarts from the beginning on its return.
- R7: From `PS_RUN`, if both flags are first seen low in the same cycle, access stays open for that cycle plus LAG_CYC = CLK_KHZ·LAG_US/1000 cycles and then closes. If `sup_sw` returns during the lag, access closes at once.
- R8: A write in progress when protection asserts is cut off in the same cycle. The cut also ends a swallowed write attempt, so `batt_low` clears on the next edge.
- R9: With access open, `ram_ce_n` = `host_ce_n`, `ram_oe_n` = `host_ce_n | host_oe_n`, `ram_we_n` = `host_ce_n | host_we_n` (flag clear), and `dq_drive` = !`host_ce_n` & !`host_oe_n` & `host_we_n`.
- R10: While `rst_n` is 0 the block is in `PS_BATT` with `batt_low` = 0 and all RAM strobes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi | input | 1 | Supply above the deselect threshold |
| sup_sw | input | 1 | Supply above the battery switchover threshold |
| batt_good | input | 1 | Battery voltage adequate (sampled at power-up) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| ram_ce_n | output | 1 | Gated chip enable to the RAM |
| ram_oe_n | output | 1 | Gated output enable to the RAM |
| ram_we_n | output | 1 | Gated write enable to the RAM |
| dq_drive | output | 1 | Data bus output driver enable (0 = high impedance) |
| batt_low | output | 1 | Battery-low flag status |

## Verification
The interesting coincidence is a supply failure that arrives while the battery-low flag is swallowing a write. The write abort and the flag's end-of-attempt detection then fall in the same cycle. The bench provokes this by powering up with `batt_good` low, opening a write once access opens, and pulling `sup_hi` low while the write strobe is still held. It expects `ram_we_n` to stay high throughout and `batt_low` to drop on the very next edge. A behavioural cycle model in the bench checks the same outputs on every clock alongside the directed checks.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [2:0] {
        PS_BATT    = 3'd0,
        PS_WINDOW  = 3'd1,
        PS_RECOVER = 3'd2,
        PS_RUN     = 3'd3,
        PS_LAG     = 3'd4
    } pfg_state_e;

    function automatic int unsigned pfg_at_least_one(input int unsigned v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/pfg_supply_fsm.sv
module pfg_supply_fsm
    import pfg_pkg::*;
#(
    parameter int unsigned REC_CYC = 2000,
    parameter int unsigned LAG_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_hi,
    input  logic       sup_sw,
    output pfg_state_e state,
    output logic       access_en,
    output logic       sample_batt
);

    localparam int unsigned MAXC = (REC_CYC > LAG_CYC) ? REC_CYC : LAG_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] LAG_LAST = CW'(LAG_CYC - 1);

    pfg_state_e    nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            PS_BATT: begin
                if (sup_sw) nxt = PS_WINDOW;
            end
            PS_WINDOW: begin
                if (!sup_sw) begin
                    nxt = PS_BATT;
                end else if (sup_hi) begin
                    nxt     = PS_RECOVER;
                    cnt_nxt = '0;
                end
            end
            PS_RECOVER: begin
                if (!sup_sw) begin
                    nxt = PS_BATT;
                end else if (!sup_hi) begin
                    nxt = PS_WINDOW;
                end else if (cnt == REC_LAST) begin
                    nxt = PS_RUN;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            PS_RUN: begin
                if (!sup_hi && !sup_sw) begin
                    nxt     = PS_LAG;
                    cnt_nxt = '0;
                end else if (!sup_hi) begin
                    nxt = PS_WINDOW;
                end
            end
            PS_LAG: begin
                if (sup_sw) begin
                    nxt = PS_WINDOW;
                end else if (cnt == LAG_LAST) begin
                    nxt = PS_BATT;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: nxt = PS_BATT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_BATT;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        access_en   = 1'b0;
        sample_batt = 1'b0;
        unique case (state)
            PS_BATT:    sample_batt = sup_sw;
            PS_WINDOW:  access_en   = 1'b0;
            PS_RECOVER: access_en   = 1'b0;
            PS_RUN:     access_en   = sup_hi || !sup_sw;
            PS_LAG:     access_en   = !sup_sw;
            default:    access_en   = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfg_batt_flag.sv
module pfg_batt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_batt,
    input  logic batt_good,
    input  logic write_req,
    output logic flag
);

    logic swallowing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag       <= 1'b0;
            swallowing <= 1'b0;
        end else if (sample_batt) begin
            flag       <= !batt_good;
            swallowing <= 1'b0;
        end else if (flag) begin
            if (write_req) begin
                swallowing <= 1'b1;
            end else if (swallowing) begin
                flag       <= 1'b0;
                swallowing <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pfg_bus_gate.sv
module pfg_bus_gate (
    input  logic access_en,
    input  logic block_wr,
    input  logic host_ce_n,
    input  logic host_oe_n,
    input  logic host_we_n,
    output logic write_req,
    output logic ram_ce_n,
    output logic ram_oe_n,
    output logic ram_we_n,
    output logic dq_drive
);

    logic sel;

    always_comb begin
        sel       = access_en && !host_ce_n;
        write_req = sel && !host_we_n;
        ram_ce_n  = !sel;
        ram_oe_n  = !(sel && !host_oe_n);
        ram_we_n  = !(write_req && !block_wr);
        dq_drive  = sel && !host_oe_n && host_we_n;
    end

endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
    import pfg_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 1000,
    parameter int unsigned REC_US  = 2000,
    parameter int unsigned LAG_US  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_hi,
    input  logic sup_sw,
    input  logic batt_good,
    input  logic host_ce_n,
    input  logic host_oe_n,
    input  logic host_we_n,
    output logic ram_ce_n,
    output logic ram_oe_n,
    output logic ram_we_n,
    output logic dq_drive,
    output logic batt_low
);

    localparam int unsigned REC_CYC = pfg_at_least_one(CLK_KHZ * REC_US / 1000);
    localparam int unsigned LAG_CYC = pfg_at_least_one(CLK_KHZ * LAG_US / 1000);

    pfg_state_e pwr_state;
    logic       access_en;
    logic       sample_batt;
    logic       write_req;

    pfg_supply_fsm #(
        .REC_CYC(REC_CYC),
        .LAG_CYC(LAG_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sup_hi     (sup_hi),
        .sup_sw     (sup_sw),
        .state      (pwr_state),
        .access_en  (access_en),
        .sample_batt(sample_batt)
    );

    pfg_batt_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_batt(sample_batt),
        .batt_good  (batt_good),
        .write_req  (write_req),
        .flag       (batt_low)
    );

    pfg_bus_gate u_gate (
        .access_en(access_en),
        .block_wr (batt_low),
        .host_ce_n(host_ce_n),
        .host_oe_n(host_oe_n),
        .host_we_n(host_we_n),
        .write_req(write_req),
        .ram_ce_n (ram_ce_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n),
        .dq_drive (dq_drive)
    );

endmodule

// File: rtl/pfg_gate_chk.sv
module pfg_gate_chk
    import pfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sup_hi,
    input logic       sup_sw,
    input logic       batt_good,
    input logic       host_ce_n,
    input logic       host_we_n,
    input logic       ram_ce_n,
    input logic       ram_oe_n,
    input logic       ram_we_n,
    input logic       dq_drive,
    input logic       batt_low,
    input pfg_state_e state
);

    p_window_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_hi && sup_sw) |-> (ram_ce_n && ram_oe_n && !dq_drive));

    p_we_needs_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && !host_we_n));

    p_batt_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BATT && sup_sw) |=> (batt_low == !$past(batt_good)));

    p_swallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        batt_low |-> ram_we_n);

    p_recover_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RECOVER) |-> (ram_ce_n && ram_we_n));

    p_lag_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_LAG && !sup_sw) |-> (ram_ce_n == host_ce_n));

endmodule

bind pfg_gate pfg_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_hi   (sup_hi),
    .sup_sw   (sup_sw),
    .batt_good(batt_good),
    .host_ce_n(host_ce_n),
    .host_we_n(host_we_n),
    .ram_ce_n (ram_ce_n),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n),
    .dq_drive (dq_drive),
    .batt_low (batt_low),
    .state    (pwr_state)
);

// File: tb/tb_pfg_gate.sv
module tb_pfg_gate;

    localparam int CLK_P   = 10;
    localparam int KHZ     = 100;
    localparam int REC     = 200;   // KHZ*2000/1000
    localparam int LAG     = 5;     // KHZ*50/1000
    localparam int WDOG    = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_hi = 1'b0, sup_sw = 1'b0, batt_good = 1'b1;
    logic host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
    logic ram_ce_n, ram_oe_n, ram_we_n, dq_drive, batt_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pfg_gate #(.CLK_KHZ(KHZ), .REC_US(2000), .LAG_US(50)) dut (
        .clk(clk), .rst_n(rst_n), .sup_hi(sup_hi), .sup_sw(sup_sw),
        .batt_good(batt_good), .host_ce_n(host_ce_n), .host_oe_n(host_oe_n),
        .host_we_n(host_we_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .dq_drive(dq_drive), .batt_low(batt_low)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 battery, 1 window, 2 recovering, 3 running, 4 lagging
    int  m_phase = 0;
    int  m_left  = 0;
    bit  m_flag  = 0;
    bit  m_taken = 0;

    function automatic bit m_open();
        if (m_phase == 3) return sup_hi || !sup_sw;
        if (m_phase == 4) return !sup_sw;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_flag = 0; m_taken = 0;
        end else begin
            bit wr;
            wr = m_open() && !host_ce_n && !host_we_n;
            if (m_phase == 0 && sup_sw) begin
                m_flag = !batt_good; m_taken = 0;
            end else if (m_flag) begin
                if (wr) m_taken = 1;
                else if (m_taken) begin m_flag = 0; m_taken = 0; end
            end
            case (m_phase)
                0: if (sup_sw) m_phase = 1;
                1: if (!sup_sw) m_phase = 0;
                   else if (sup_hi) begin m_phase = 2; m_left = REC; end
                2: if (!sup_sw) m_phase = 0;
                   else if (!sup_hi) m_phase = 1;
                   else begin m_left--; if (m_left == 0) m_phase = 3; end
                3: if (!sup_hi) begin
                       if (!sup_sw) begin m_phase = 4; m_left = LAG; end
                       else m_phase = 1;
                   end
                4: if (sup_sw) m_phase = 1;
                   else begin m_left--; if (m_left == 0) m_phase = 0; end
                default: m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        if (!done) begin
            bit en;
            en = m_open();
            chk("R1", "model ram_ce_n", ram_ce_n, !(en && !host_ce_n));
            chk("R1", "model ram_oe_n", ram_oe_n, !(en && !host_ce_n && !host_oe_n));
            chk("R2", "model ram_we_n", ram_we_n, !(en && !host_ce_n && !host_we_n && !m_flag));
            chk("R9", "model dq_drive", dq_drive, en && !host_ce_n && !host_oe_n && host_we_n);
            chk("R5", "model batt_low", batt_low, m_flag);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host(input logic ce, input logic oe, input logic we);
        host_ce_n = ce; host_oe_n = oe; host_we_n = we;
    endtask

    // Raises both supply flags from battery mode; returns at the first negedge of open access
    task automatic power_up(input logic bg);
        @(negedge clk);
        sup_sw = 1'b1; batt_good = bg;
        @(negedge clk);
        sup_hi = 1'b1; batt_good = !bg;     // R3: later value must be ignored
        host(1'b0, 1'b0, 1'b1);
        #2 chk("R3", "batt_low after sample", batt_low, !bg);
        cyc(REC);
        #2 chk("R6", "ram_ce_n last recovery cycle", ram_ce_n, 1'b1);
        cyc(1);
        #2 chk("R6", "ram_ce_n after recovery", ram_ce_n, 1'b0);
        chk("R3", "batt_low unchanged by later batt_good", batt_low, !bg);
        if (!bg) chk("R9", "dq_drive read open", dq_drive, 1'b1);
    endtask

    task automatic power_down();
        @(negedge clk);
        host(1'b1, 1'b1, 1'b1);
        sup_hi = 1'b0;
        @(negedge clk);
        sup_sw = 1'b0;
        cyc(2);
    endtask

    initial begin
        #(CLK_P * WDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        #2 chk("R10", "ram_ce_n in reset", ram_ce_n, 1'b1);
        chk("R10", "batt_low in reset", batt_low, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        host(1'b0, 1'b0, 1'b0);
        #2 chk("R10", "ram_we_n after reset, no supply", ram_we_n, 1'b1);
        @(negedge clk);
        host(1'b1, 1'b1, 1'b1);

        // Good battery power-up, normal access
        power_up(1'b1);
        chk("R9", "dq_drive read", dq_drive, 1'b1);
        @(negedge clk); host(1'b0, 1'b1, 1'b0);
        #2 chk("R9", "ram_we_n write", ram_we_n, 1'b0);
        chk("R9", "dq_drive off during write", dq_drive, 1'b0);
        @(negedge clk); host(1'b0, 1'b0, 1'b1);
        #2 chk("R9", "ram_oe_n read", ram_oe_n, 1'b0);

        // Slow fall during a read then a write attempt in the window
        @(negedge clk); sup_hi = 1'b0;
        #2 chk("R1", "ram_ce_n on slow fall", ram_ce_n, 1'b1);
        chk("R1", "dq_drive on slow fall", dq_drive, 1'b0);
        @(negedge clk); host(1'b0, 1'b1, 1'b0);
        #2 chk("R2", "ram_we_n in window", ram_we_n, 1'b1);
        power_down();

        // Low battery power-up: one write swallowed
        power_up(1'b0);
        @(negedge clk); host(1'b0, 1'b1, 1'b0);
        #2 chk("R4", "ram_we_n swallowed", ram_we_n, 1'b1);
        chk("R4", "ram_ce_n passes", ram_ce_n, 1'b0);
        cyc(2);
        #2 chk("R4", "ram_we_n still swallowed", ram_we_n, 1'b1);
        chk("R5", "batt_low during attempt", batt_low, 1'b1);
        @(negedge clk); host(1'b1, 1'b1, 1'b1);
        #2 chk("R5", "batt_low before clearing edge", batt_low, 1'b1);
        @(negedge clk);
        #2 chk("R5", "batt_low cleared", batt_low, 1'b0);
        host(1'b0, 1'b1, 1'b0);
        #2 chk("R5", "next write passes", ram_we_n, 1'b0);

        // Write in progress on slow fall
        @(negedge clk); sup_hi = 1'b0;
        #2 chk("R8", "write cut on protection", ram_we_n, 1'b1);
        power_down();

        // Fast fall while writing
        power_up(1'b1);
        @(negedge clk); host(1'b0, 1'b1, 1'b0);
        @(negedge clk); sup_hi = 1'b0; sup_sw = 1'b0;
        #2 chk("R7", "write open at crossing", ram_we_n, 1'b0);
        cyc(LAG);
        #2 chk("R7", "write open last lag cycle", ram_we_n, 1'b0);
        cyc(1);
        #2 chk("R7", "write blocked after lag", ram_we_n, 1'b1);
        host(1'b1, 1'b1, 1'b1);
        cyc(2);

        // Fast fall cut by switchover return, then recovery restart
        power_up(1'b1);
        @(negedge clk); sup_hi = 1'b0; sup_sw = 1'b0;
        cyc(2);
        sup_sw = 1'b1;
        #2 chk("R7", "lag cut on switchover return", ram_ce_n, 1'b1);
        cyc(3);
        sup_hi = 1'b1;
        cyc(10);
        sup_hi = 1'b0;
        @(negedge clk); sup_hi = 1'b1;
        cyc(REC);
        #2 chk("R6", "restarted recovery still closed", ram_ce_n, 1'b1);
        cyc(1);
        #2 chk("R6", "restarted recovery opens", ram_ce_n, 1'b0);
        power_down();

        // Coincidence: swallowed write cut by supply failure
        power_up(1'b0);
        @(negedge clk); host(1'b0, 1'b1, 1'b0);
        cyc(2);
        sup_hi = 1'b0;
        #2 chk("R8", "ram_we_n on abort", ram_we_n, 1'b1);
        chk("R8", "batt_low before abort edge", batt_low, 1'b1);
        @(negedge clk);
        #2 chk("R8", "batt_low cleared by abort", batt_low, 1'b0);
        power_down();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule